// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block sits between a peripheral's bus write port and its configuration registers and decides, write by write, whether a store to a guarded register may take effect. A dedicated key address accepts byte writes. Only the ordered pair of key bytes, first 0xCA and then 0x53, opens the gate. Any other key byte closes it again at once.

While the gate is closed, writes to the guarded registers are suppressed by a low write-enable qualifier. Those registers are the time and date registers, the register that holds the init-mode request bit, and the control register. A suppressed write is not reported in any way. Reads never pass through the gate. The register file owner ANDs the qualifier into the write enables of its guarded registers.

Writes to any other address, including the key address, never raise the qualifier. Apart from key writes, they leave the lock state untouched. The gate state is brought out so that the surrounding logic can observe it.

Top module: `wlk_gate`

## Requirements
- R1: After a cycle with `rst_n` low, the gate is closed (`gate_open` = 0) and `prot_wr_ok` is 0.
- R2: While the gate is closed, `prot_wr_ok` stays 0 for every write, including writes to guarded addresses 0x00, 0x04, 0x0C and 0x18.
- R3: A key write (address 0x24) of 0xCA followed by a key write of 0x53 opens the gate; `gate_open` is 1 from the cycle after the second key write.
- R4: While the gate is open, a write to one of the guarded addresses raises `prot_wr_ok` in the same cycle as `bus_wr`.
- R5: A first key byte other than 0xCA leaves the gate closed, and a following 0x53 does not open it.
- R6: After 0xCA, any second key byte other than 0x53 returns the sequence to its start, so a later single 0x53 does not open the gate.
- R7: While the gate is open, any key write (0xFF or any other byte, 0x53 and 0xCA included) closes it from the next cycle.
- R8: Writes to addresses other than 0x24 do not change the lock state or the progress of the key sequence.
- R9: A write to an address outside the guarded set never raises `prot_wr_ok`, open or closed.
- R10: Without `bus_wr`, address and data inputs have no effect on the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Write address |
| bus_wdata | input | KEY_W (8) | Low byte of the write data, compared as a key |
| prot_wr_ok | output | 1 | Write enable qualifier for the guarded registers |
| gate_open | output | 1 | Lock state, 1 when guarded writes are allowed |

## Verification
A lock state machine stuck in the wrong state shows on `gate_open` one cycle after the key write that should have moved it. It shows on `prot_wr_ok` during the very next guarded write. A half-step state that wrongly survives a bad key, or a wrong non-key write, appears only after a later single 0x53 opens the gate. For that reason, every sweep ends its sequence with the second key and then reads `gate_open`. A wrong address decode shows at once on `prot_wr_ok` for the address it misclassifies, which the full address sweep in both lock states exposes.

// File: rtl/wlk_pkg.sv
// Package: shared types and default constants of the two-key write lock.
// Assumes byte-wide keys and an 8-bit register address space by default.
package wlk_pkg;

    // Lock progress: closed, first key seen, open.
    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lk_state_e;

    localparam int unsigned DEF_ADDR_W = 8;
    localparam int unsigned DEF_KEY_W  = 8;

endpackage

// File: rtl/wlk_addr_match.sv
// Module: wlk_addr_match
// Classifies a bus address as the key address, as one of the guarded
// registers, or as neither. Purely combinational.
// Assumes the key address is not in the guarded list.
module wlk_addr_match #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_PROT = 4,
    parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = '0,
    parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_key,
    output logic              hit_prot
);

    logic [NUM_PROT-1:0] hit_vec;

    // One comparator per guarded address.
    for (genvar i = 0; i < NUM_PROT; i++) begin : g_cmp
        assign hit_vec[i] = (addr == PROT_ADDRS[i*ADDR_W +: ADDR_W]);
    end

    // Reduce the per-address hits and decode the key address.
    always_comb begin
        hit_prot = |hit_vec;
        hit_key  = (addr == KEY_ADDR);
    end

endmodule

// File: rtl/wlk_key_fsm.sv
// Module: wlk_key_fsm
// Tracks the key sequence. Only key writes move it: the first key takes it
// from closed to half, the second key from half to open, and any other key
// byte in any state returns it to closed.
// Assumes key_wr is a single-cycle pulse per bus write.
module wlk_key_fsm
    import wlk_pkg::*;
#(
    parameter int unsigned KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             is_open
);

    lk_state_e state_q, state_d;

    // Next-state rule for one key write.
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                LK_CLOSED: state_d = (key_val == KEY_FIRST)  ? LK_HALF : LK_CLOSED;
                LK_HALF:   state_d = (key_val == KEY_SECOND) ? LK_OPEN : LK_CLOSED;
                default:   state_d = LK_CLOSED;
            endcase
        end
    end

    // State register with synchronous reset to closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode the open state.
    always_comb begin
        is_open = (state_q == LK_OPEN);
    end

endmodule

// File: rtl/wlk_gate.sv
// Module: wlk_gate (top)
// Write-protection gate for a peripheral's configuration registers.
// Produces a same-cycle write qualifier for the guarded addresses and
// exposes the lock state. Reads are not routed through this block.
// Assumes one bus write per asserted bus_wr cycle.
module wlk_gate
    import wlk_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned KEY_W    = DEF_KEY_W,
    parameter int unsigned NUM_PROT = 4,
    parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = {8'h18, 8'h0C, 8'h04, 8'h00},
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h24,
    parameter logic [KEY_W-1:0]  KEY_FIRST  = 8'hCA,
    parameter logic [KEY_W-1:0]  KEY_SECOND = 8'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0]  bus_wdata,
    output logic              prot_wr_ok,
    output logic              gate_open
);

    logic hit_key;
    logic hit_prot;
    logic fsm_open;

    wlk_addr_match #(
        .ADDR_W    (ADDR_W),
        .NUM_PROT  (NUM_PROT),
        .PROT_ADDRS(PROT_ADDRS),
        .KEY_ADDR  (KEY_ADDR)
    ) u_match (
        .addr    (bus_addr),
        .hit_key (hit_key),
        .hit_prot(hit_prot)
    );

    wlk_key_fsm #(
        .KEY_W     (KEY_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_wr (bus_wr & hit_key),
        .key_val(bus_wdata),
        .is_open(fsm_open)
    );

    // Qualify guarded writes with the current lock state.
    always_comb begin
        prot_wr_ok = bus_wr & hit_prot & fsm_open;
        gate_open  = fsm_open;
    end

endmodule

// File: rtl/wlk_gate_chk.sv
// Module: wlk_gate_chk
// Property checker for wlk_gate, attached with bind below.
module wlk_gate_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned KEY_W    = 8,
    parameter int unsigned NUM_PROT = 4,
    parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = '0,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = '0,
    parameter logic [KEY_W-1:0]  KEY_SECOND = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [KEY_W-1:0]  bus_wdata,
    input logic              prot_wr_ok,
    input logic              gate_open
);

    logic in_set;
    logic key_wr;

    // Independent membership test of the guarded list.
    always_comb begin
        in_set = 1'b0;
        for (int i = 0; i < NUM_PROT; i++) begin
            if (bus_addr == PROT_ADDRS[i*ADDR_W +: ADDR_W]) in_set = 1'b1;
        end
        key_wr = bus_wr && (bus_addr == KEY_ADDR);
    end

    AST_RESET_CLOSES: assert property (@(posedge clk)
        !rst_n |=> !gate_open); // R1

    AST_QUAL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_ok |-> gate_open); // R2

    AST_OPEN_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> ($past(key_wr) && $past(bus_wdata) == KEY_SECOND)); // R3

    AST_OPEN_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && bus_wr && in_set) |-> prot_wr_ok); // R4

    AST_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && key_wr) |=> !gate_open); // R7

    AST_OUTSIDE_NO_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_set |-> !prot_wr_ok); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(gate_open)); // R10

endmodule

bind wlk_gate wlk_gate_chk #(
    .ADDR_W    (ADDR_W),
    .KEY_W     (KEY_W),
    .NUM_PROT  (NUM_PROT),
    .PROT_ADDRS(PROT_ADDRS),
    .KEY_ADDR  (KEY_ADDR),
    .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .prot_wr_ok(prot_wr_ok),
    .gate_open (gate_open)
);

// File: tb/wlk_gate_tb.sv
// Bench for wlk_gate: sweeps key bytes and addresses against a bench model.
module wlk_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       prot_wr_ok;
    logic       gate_open;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic last_qual;

    always #5 clk = ~clk;

    wlk_gate u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .prot_wr_ok(prot_wr_ok), .gate_open(gate_open)
    );

    function automatic bit guarded(input logic [7:0] a);
        return (a == 8'h00) || (a == 8'h04) || (a == 8'h0C) || (a == 8'h18);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One bus write: qualifier sampled mid-cycle, state visible on return.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #2 last_qual = prot_wr_ok;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic relock();
        wr(8'h24, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 gate closed in reset", gate_open, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 gate closed after reset", gate_open, 1'b0);
        check("R1 qualifier low after reset", prot_wr_ok, 1'b0);

        // R2 and R9: every address while closed.
        for (int a = 0; a < 256; a++) begin
            if (a == 8'h24) continue;
            wr(a[7:0], 8'hCA);
            check("R2 closed write not qualified", last_qual, 1'b0);
        end
        check("R8 non-key writes leave gate closed", gate_open, 1'b0);

        // R3 and R5: sweep the first key byte, then give the second key.
        for (int b = 0; b < 256; b++) begin
            wr(8'h24, b[7:0]);
            wr(8'h24, 8'h53);
            if (b == 8'hCA) check("R3 correct pair opens", gate_open, 1'b1);
            else            check("R5 wrong first key keeps closed", gate_open, 1'b0);
            relock();
        end

        // R6: sweep the second key byte after 0xCA, then try a lone 0x53.
        for (int b = 0; b < 256; b++) begin
            wr(8'h24, 8'hCA);
            wr(8'h24, b[7:0]);
            if (b == 8'h53) begin
                check("R3 second key opens", gate_open, 1'b1);
            end else begin
                check("R6 wrong second key keeps closed", gate_open, 1'b0);
                wr(8'h24, 8'h53);
                check("R6 sequence restarted", gate_open, 1'b0);
            end
            relock();
        end

        // R7: sweep every key byte while open.
        for (int b = 0; b < 256; b++) begin
            wr(8'h24, 8'hCA);
            wr(8'h24, 8'h53);
            check("R3 open before relock", gate_open, 1'b1);
            wr(8'h24, b[7:0]);
            check("R7 key write relocks", gate_open, 1'b0);
        end

        // R4 and R9: every address while open.
        wr(8'h24, 8'hCA);
        wr(8'h24, 8'h53);
        for (int a = 0; a < 256; a++) begin
            if (a == 8'h24) continue;
            wr(a[7:0], 8'h00);
            if (guarded(a[7:0])) check("R4 open guarded write qualified", last_qual, 1'b1);
            else                 check("R9 unguarded write not qualified", last_qual, 1'b0);
        end
        check("R8 non-key writes keep gate open", gate_open, 1'b1);
        relock();

        // R8: non-key writes between the keys do not break the sequence.
        wr(8'h24, 8'hCA);
        wr(8'h40, 8'h11);
        wr(8'h00, 8'h53);
        check("R2 guarded write mid-sequence not qualified", last_qual, 1'b0);
        wr(8'h24, 8'h53);
        check("R8 sequence survives other writes", gate_open, 1'b1);
        relock();

        // R10: idle bus with key-looking inputs does not move the state.
        @(negedge clk);
        bus_addr = 8'h24; bus_wdata = 8'hCA;
        repeat (4) @(negedge clk);
        wr(8'h24, 8'h53);
        check("R10 idle inputs ignored", gate_open, 1'b0);

        // R1: reset while open closes the gate.
        wr(8'h24, 8'hCA);
        wr(8'h24, 8'h53);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset closes open gate", gate_open, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule